// File: doc/BRIEF.md
# Bit-Serial BCD Adder-Subtractor

This block adds or subtracts two unsigned decimal numbers of twelve BCD digits, one bit per clock, least significant bit first. The datapath is one full adder with a carry flip-flop. An XOR on the second operand turns addition into subtraction, and the carry then acts as a borrow. The raw binary sum of each digit is gathered in a three-bit holding stage. When the fourth bit of the digit arrives, a decimal adjust step writes a valid BCD digit into the result word and places the decimal carry or borrow in the carry flip-flop, ready for the next digit.

The operands and the result live in word-long shift registers that rotate by one position every clock. The stored words therefore keep a fixed alignment to the system word timing, which is 48 clocks for the default twelve digits. An operation starts on a start pulse given in a word-boundary cycle. It streams the operand bits in over the next word, or takes them from the stored copies when chaining. It then raises done for one cycle together with the final carry or borrow. After that, the result word streams out continuously.

Top module: `serial_bcd_addsub`

## Requirements
- R1: With sub_sel=0 at the accept cycle, the result word is (A+B) mod 10^12. Digit i occupies bits 4i..4i+3 of the word, bit 0 is the least significant bit and travels first, and each digit is coded in 8-4-2-1 BCD.
- R2: At the end of an addition, cb_flag is 1 when A+B is at least 10^12 and 0 otherwise.
- R3: With sub_sel=1 at the accept cycle, the result word is A-B when A>=B, with cb_flag=0. When A<B, the result word is 10^12-(B-A) (the tens complement) and cb_flag=1 (borrow).
- R4: At the accept cycle the carry flip-flop is cleared for an addition and set for a subtraction. sub_sel is used only at the accept cycle, so changes to it during the operation have no effect.
- R5: start is accepted only in a cycle where word_sync=1 and no operation is running. A start at any other time does not change done, cb_flag or the stored result.
- R6: Operand bit k is taken in cycle k+1 after the accept cycle. done is 1 in cycle 49 after the accept cycle only, and is 0 in every other cycle.
- R7: res_ser carries result bit k in cycle 49+k after the accept cycle. While idle, the result word repeats every 48 cycles.
- R8: cb_flag keeps its value from one done pulse to the next.
- R9: An operation with reuse_ops=0 stores the streamed operands. With reuse_ops=1 at the accept cycle, the operation uses the stored words, ignores a_ser and b_ser, and leaves the stored words unchanged.
- R10: After reset, done=0, cb_flag=0, and the result word and the stored operands are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Operation request, honoured only with word_sync |
| word_sync | input | 1 | High in the word-boundary cycle, once every 48 cycles |
| sub_sel | input | 1 | 1 selects A-B, 0 selects A+B |
| reuse_ops | input | 1 | 1 takes the operands from the stored words |
| a_ser | input | 1 | Serial operand A, LSB first |
| b_ser | input | 1 | Serial operand B, LSB first |
| res_ser | output | 1 | Serial result word, LSB first |
| cb_flag | output | 1 | Final decimal carry (add) or borrow (subtract) |
| done | output | 1 | One-cycle end-of-operation strobe |

## Verification
Everything is timed from the accept cycle. Operand bit k is driven for cycle k+1. done and cb_flag are due in cycle 49. Result bit k is due in cycle 49+k, and again every 48 cycles after that. The bench keeps its own phase counter that produces word_sync, so it always knows which cycle it is in. It drives inputs and samples outputs at the falling edge, so every value it reads is the one left by the preceding rising edge. Expected words come from integer models of decimal addition and subtraction with wrap-around at 10^12.

// File: rtl/bcd_ser_pkg.sv
package bcd_ser_pkg;

   localparam int DIGIT_W    = 4;
   localparam int MIN_DIGITS = 2;
   localparam int MAX_DIGITS = 16;

   typedef enum logic {
      OP_ADD = 1'b0,
      OP_SUB = 1'b1
   } op_e;

   // returns {decimal_carry, adjusted_digit}
   function automatic logic [DIGIT_W:0] dec_adjust(op_e op, logic c4, logic [DIGIT_W-1:0] raw);
      logic [DIGIT_W-1:0] dig;
      logic               cy;
      if (op == OP_ADD) begin
         cy  = c4 | (raw > 4'd9);
         dig = cy ? raw + 4'd6 : raw;
      end else begin
         cy  = c4;                        // 1 = no borrow out of this digit
         dig = c4 ? raw : raw + 4'd10;
      end
      return {cy, dig};
   endfunction

endpackage

// File: rtl/ser_full_adder.sv
module ser_full_adder (
   input  logic a,
   input  logic b,
   input  logic inv,
   input  logic cin,
   output logic s,
   output logic cout
);
   logic b_eff;
   logic half;

   assign b_eff = b ^ inv;
   assign half  = a ^ b_eff;
   assign s     = half ^ cin;
   assign cout  = (a & b_eff) | (cin & half);
endmodule

// File: rtl/ser_word_reg.sv
module ser_word_reg #(
   parameter int W = 48
) (
   input  logic clk,
   input  logic rst,
   input  logic wr_en,
   input  logic din,
   output logic tap
);
   logic [W-1:0] q;

   always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= {(wr_en ? din : q[0]), q[W-1:1]};
   end

   assign tap = q[0];
endmodule

// File: rtl/dec_correct.sv
module dec_correct
   import bcd_ser_pkg::*;
(
   input  op_e                op,
   input  logic               c4,
   input  logic [DIGIT_W-1:0] raw,
   output logic [DIGIT_W-1:0] digit,
   output logic               dcarry
);
   logic [DIGIT_W:0] adj;

   always_comb begin
      adj    = dec_adjust(op, c4, raw);
      digit  = adj[DIGIT_W-1:0];
      dcarry = adj[DIGIT_W];
   end
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl #(
   parameter int W = 48
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 start,
   input  logic                 word_sync,
   output logic                 accept,
   output logic                 busy,
   output logic                 last,
   output logic                 digit_end,
   output logic                 done
);
   localparam int IW = $clog2(W);

   logic [IW-1:0] idx;

   assign accept    = start & word_sync & ~busy;
   assign last      = busy & (idx == IW'(W-1));
   assign digit_end = busy & (idx[1:0] == 2'b11);

   always_ff @(posedge clk) begin
      if (rst) begin
         busy <= 1'b0;
         idx  <= '0;
         done <= 1'b0;
      end else begin
         done <= last;
         if (accept) begin
            busy <= 1'b1;
            idx  <= '0;
         end else if (busy) begin
            idx <= idx + 1'b1;
            if (last) busy <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/serial_bcd_addsub.sv
module serial_bcd_addsub
   import bcd_ser_pkg::*;
#(
   parameter int DIGITS = 12
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   input  logic word_sync,
   input  logic sub_sel,
   input  logic reuse_ops,
   input  logic a_ser,
   input  logic b_ser,
   output logic res_ser,
   output logic cb_flag,
   output logic done
);
   localparam int W  = DIGITS * DIGIT_W;
   localparam int HW = DIGIT_W - 1;

   generate
      if (DIGITS < MIN_DIGITS || DIGITS > MAX_DIGITS) begin : g_bad_digits
         $error("serial_bcd_addsub: DIGITS out of supported range");
      end
   endgenerate

   logic          accept, busy, last, digit_end;
   op_e           op_q;
   logic          reuse_q;
   logic          cy;
   logic [HW-1:0] hold;
   logic [W-1:0]  res_q;
   logic          flag_q;

   // operand storage, one recirculating word per operand
   logic [1:0] strm, tap, obit;
   assign strm = {b_ser, a_ser};

   for (genvar g = 0; g < 2; g++) begin : g_opnd
      ser_word_reg #(.W(W)) u_word (
         .clk   (clk),
         .rst   (rst),
         .wr_en (busy & ~reuse_q),
         .din   (strm[g]),
         .tap   (tap[g])
      );
      assign obit[g] = reuse_q ? tap[g] : strm[g];
   end

   seq_ctrl #(.W(W)) u_seq (
      .clk       (clk),
      .rst       (rst),
      .start     (start),
      .word_sync (word_sync),
      .accept    (accept),
      .busy      (busy),
      .last      (last),
      .digit_end (digit_end),
      .done      (done)
   );

   logic sum_b, c_out;

   ser_full_adder u_fa (
      .a    (obit[0]),
      .b    (obit[1]),
      .inv  (op_q == OP_SUB),
      .cin  (cy),
      .s    (sum_b),
      .cout (c_out)
   );

   logic [DIGIT_W-1:0] fix_d;
   logic               fix_c;

   dec_correct u_fix (
      .op     (op_q),
      .c4     (c_out),
      .raw    ({sum_b, hold}),
      .digit  (fix_d),
      .dcarry (fix_c)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         op_q    <= OP_ADD;
         reuse_q <= 1'b0;
         cy      <= 1'b0;
         hold    <= '0;
         res_q   <= '0;
         flag_q  <= 1'b0;
      end else begin
         if (accept) begin
            op_q    <= op_e'(sub_sel);
            reuse_q <= reuse_ops;
            cy      <= sub_sel;
         end else if (busy) begin
            cy <= digit_end ? fix_c : c_out;
         end

         if (busy) begin
            hold  <= {sum_b, hold[HW-1:1]};
            res_q <= digit_end ? {fix_d, res_q[W-DIGIT_W:1]} : {sum_b, res_q[W-1:1]};
         end else begin
            res_q <= {res_q[0], res_q[W-1:1]};
         end

         if (last) flag_q <= (op_q == OP_SUB) ? ~fix_c : fix_c;
      end
   end

   assign res_ser = res_q[0];
   assign cb_flag = flag_q;
endmodule

// File: rtl/bcd_addsub_chk.sv
module bcd_addsub_chk #(
   parameter int W = 48
) (
   input logic         clk,
   input logic         rst,
   input logic         start,
   input logic         word_sync,
   input logic         sub_sel,
   input logic         done,
   input logic         cb_flag,
   input logic         busy,
   input logic         cy,
   input logic [W-1:0] res_q
);
   localparam int KW = $clog2(W + 2);

   logic [KW-1:0] k;

   always_ff @(posedge clk) begin
      if (rst)                              k <= '0;
      else if (start && word_sync && !busy) k <= KW'(1);
      else if (k != '0 && k != KW'(W + 1))  k <= k + 1'b1;
      else                                  k <= '0;
   end

   p_done_one_cycle_r6: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   p_done_after_word_r6: assert property (@(posedge clk) disable iff (rst)
      done |-> (k == KW'(W + 1)));

   p_busy_for_word_r5: assert property (@(posedge clk) disable iff (rst)
      (k != '0 && k <= KW'(W)) |-> busy);

   p_carry_preset_r4: assert property (@(posedge clk) disable iff (rst)
      (start && word_sync && !busy) |=> (cy == $past(sub_sel)));

   p_flag_held_r8: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && !$stable(cb_flag)) |-> done);

   p_res_rotates_r7: assert property (@(posedge clk) disable iff (rst)
      ($past(!rst) && $past(!busy)) |-> (res_q == {$past(res_q[0]), $past(res_q[W-1:1])}));
endmodule

bind serial_bcd_addsub bcd_addsub_chk #(.W(W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .start     (start),
   .word_sync (word_sync),
   .sub_sel   (sub_sel),
   .done      (done),
   .cb_flag   (cb_flag),
   .busy      (busy),
   .cy        (cy),
   .res_q     (res_q)
);

// File: tb/sim_serial_bcd_addsub.sv
module sim_serial_bcd_addsub;
   localparam int CLK_NS = 10;
   localparam int ND     = 12;
   localparam int W      = ND * 4;
   localparam longint unsigned MODV = 64'd1000000000000;

   logic clk = 1'b0, rst = 1'b1, start = 1'b0, word_sync = 1'b0;
   logic sub_sel = 1'b0, reuse_ops = 1'b0, a_ser = 1'b0, b_ser = 1'b0;
   logic res_ser, cb_flag, done;

   int checks = 0, bad = 0, ph = 0;
   bit finished = 0;
   logic [W-1:0] st_a = '0, st_b = '0, last_res = '0;
   logic         last_flag = 1'b0;

   always #(CLK_NS/2) clk = ~clk;

   serial_bcd_addsub #(.DIGITS(ND)) u0 (
      .clk(clk), .rst(rst), .start(start), .word_sync(word_sync),
      .sub_sel(sub_sel), .reuse_ops(reuse_ops), .a_ser(a_ser), .b_ser(b_ser),
      .res_ser(res_ser), .cb_flag(cb_flag), .done(done)
   );

   task automatic tick();
      @(negedge clk);
      ph = (ph + 1) % W;
      word_sync = (ph == 0);
   endtask

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic longint unsigned to_num(logic [W-1:0] v);
      longint unsigned r = 0;
      for (int i = ND - 1; i >= 0; i--) r = r * 10 + longint'(v[i*4 +: 4]);
      return r;
   endfunction

   function automatic logic [W-1:0] to_bcd(longint unsigned n);
      logic [W-1:0] v = '0;
      for (int i = 0; i < ND; i++) begin
         v[i*4 +: 4] = 4'(n % 10);
         n = n / 10;
      end
      return v;
   endfunction

   function automatic logic [W-1:0] rand_bcd();
      logic [W-1:0] v;
      for (int i = 0; i < ND; i++) v[i*4 +: 4] = 4'($urandom % 10);
      return v;
   endfunction

   // word read: result bit k is present when ph == (k+1) % W
   task automatic read_word(output logic [W-1:0] w);
      while (ph != 0) tick();
      for (int k = 0; k < W; k++) begin
         tick();
         w[k] = res_ser;
      end
   endtask

   task automatic run_op(logic [W-1:0] a, logic [W-1:0] b, bit sub, bit reuse, bit poke, string tag);
      logic [W-1:0] ea, eb, got, exp_w;
      longint unsigned na, nb;
      logic exp_f;
      int extra_done = 0;
      ea = reuse ? st_a : a;
      eb = reuse ? st_b : b;
      na = to_num(ea);
      nb = to_num(eb);
      if (!sub) begin
         exp_w = to_bcd((na + nb) % MODV);
         exp_f = (na + nb) >= MODV;
      end else if (na >= nb) begin
         exp_w = to_bcd(na - nb);
         exp_f = 1'b0;
      end else begin
         exp_w = to_bcd(MODV - (nb - na));
         exp_f = 1'b1;
      end
      while (ph != W - 1) tick();
      tick();                                   // word boundary cycle
      start = 1'b1; sub_sel = sub; reuse_ops = reuse;
      for (int k = 0; k < W; k++) begin
         tick();
         start   = poke && (k == W - 1);        // busy-time start, must be ignored (R5)
         sub_sel = 1'($urandom);                // no effect after accept (R4)
         a_ser   = reuse ? 1'($urandom) : a[k]; // ignored when reusing (R9)
         b_ser   = reuse ? 1'($urandom) : b[k];
      end
      tick();                                   // cycle 49 after accept
      start = 1'b0;
      chk("R6", {tag, " done pulse"}, 64'(done), 64'd1);
      chk(sub ? "R3" : "R2", {tag, " carry/borrow"}, 64'(cb_flag), 64'(exp_f));
      got[0] = res_ser;
      for (int k = 1; k < W; k++) begin
         tick();
         if (done) extra_done++;
         got[k] = res_ser;
      end
      chk("R6", {tag, " done single"}, 64'(extra_done), 64'd0);
      chk(sub ? "R3" : "R1", {tag, " result"}, 64'(got), 64'(exp_w));
      chk("R8", {tag, " flag held"}, 64'(cb_flag), 64'(exp_f));
      read_word(got);
      chk("R7", {tag, " result repeats"}, 64'(got), 64'(exp_w));
      if (!reuse) begin st_a = a; st_b = b; end
      last_res  = exp_w;
      last_flag = exp_f;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] w, ra, rb;
      int seen;
      void'($urandom(32'd2024));
      repeat (4) tick();
      rst = 1'b0;
      tick();
      chk("R10", "done after reset", 64'(done), 64'd0);
      chk("R10", "flag after reset", 64'(cb_flag), 64'd0);
      read_word(w);
      chk("R10", "result after reset", 64'(w), 64'd0);
      // stored operands are zero after reset: reuse gives 0-0
      run_op('0, '0, 1'b1, 1'b1, 1'b0, "R10 reuse zero");

      run_op(to_bcd(64'd999999999999), to_bcd(64'd1), 1'b0, 1'b0, 1'b0, "R1 R2 wrap");
      run_op('0, '0, 1'b0, 1'b0, 1'b1, "R1 zero");
      run_op(to_bcd(64'd555555555555), to_bcd(64'd555555555555), 1'b0, 1'b0, 1'b0, "R2 fives");
      run_op(to_bcd(64'd123456789012), to_bcd(64'd987654321098), 1'b0, 1'b0, 1'b0, "R2 mixed");
      run_op('0, to_bcd(64'd1), 1'b1, 1'b0, 1'b0, "R3 zero minus one");
      run_op(to_bcd(64'd400000000000), to_bcd(64'd400000000000), 1'b1, 1'b0, 1'b1, "R4 equal");
      run_op(to_bcd(64'd900000000001), to_bcd(64'd99999999999), 1'b1, 1'b0, 1'b0, "R3 borrow chain");
      run_op('0, '0, 1'b0, 1'b1, 1'b0, "R9 reuse add");
      run_op('0, '0, 1'b1, 1'b1, 1'b0, "R9 reuse sub");

      // start outside the word boundary is ignored (R5)
      while (ph != 0) tick();
      seen = 0;
      for (int j = 1; j < W; j++) begin
         tick();
         start = 1'b1; a_ser = 1'b1; b_ser = 1'b1;
         if (done) seen++;
      end
      start = 1'b0;
      for (int j = 0; j < W + 2; j++) begin
         tick();
         if (done) seen++;
      end
      chk("R5", "no done without sync", 64'(seen), 64'd0);
      chk("R5", "flag kept", 64'(cb_flag), 64'(last_flag));
      read_word(w);
      chk("R5", "result kept", 64'(w), 64'(last_res));

      for (int i = 0; i < 24; i++) begin
         ra = rand_bcd();
         rb = (i % 7 == 3) ? ra : rand_bcd();
         run_op(ra, rb, 1'($urandom), (i % 5 == 4), (i % 3 == 0), "R1 R3 random");
      end

      finished = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule